// File: doc/BRIEF.md
# Single-Line NMI Request Controller

This block watches one external non-maskable interrupt pin and turns it into a single interrupt request for a parent interrupt controller. The pin is resynchronised into the bus clock domain. One of four trigger rules is then applied to it: active-low level, active-high level, rising edge or falling edge. A qualifying event sets a sticky pending flag. The request output is raised while that flag and an enable bit are both set.

Software reaches the block through a 32-bit APB-style register port. A control word selects the trigger rule. A pending word is cleared by writing a one to bit 0. An enable word masks or unmasks the request. A layout parameter places the enable word at one of two offsets, so the block can fit either of two address maps. In a level mode the pending flag is set again on every cycle the pin stays active. Software must therefore clear pending only after the source has gone inactive, or a second request follows as soon as the output is unmasked.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control, pending and enable words all read 0 and `irq_o` is low; the pin synchroniser resets to the high (inactive) level.
- R2: The control word at offset 0x00 holds the trigger code in bits [1:0]: 0 active-low level, 1 falling edge, 2 active-high level, 3 rising edge. Writes change only those bits, and bits [31:2] read 0.
- R3: In code 2 the pending flag is set on every cycle the synchronised pin is high. A pin rise made just after one clock edge shows on `irq_o` (with enable set) after the third following rising edge and not after the second.
- R4: In code 0 the pending flag is set on every cycle the synchronised pin is low.
- R5: In code 3 only a low-to-high transition of the synchronised pin sets pending. A falling transition does not, and a steady high level does not set it again after a clear.
- R6: In code 1 only a high-to-low transition sets pending. A steady low level does not set it again after a clear.
- R7: Pending is read at offset 0x04, bit 0. Writing 1 to bit 0 clears it, and writing 0 has no effect.
- R8: The enable bit is bit 0 of the word at offset 0x08 when `ALT_LAYOUT` is 0, and at offset 0x34 when it is 1. A write to the other layout's offset leaves the enable bit unchanged.
- R9: `irq_o` is high exactly when pending and enable are both set. Pending latches events while enable is 0.
- R10: When a clear write and a trigger event fall in the same cycle, pending stays set.
- R11: Changing the trigger code while the pin is steady produces no event by itself when the new code is an edge code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| nmi_pin_i | input | 1 | Asynchronous external interrupt pin |
| irq_o | output | 1 | Request toward the parent controller |

## Verification
The bench clears pending while a level-mode pin is still active. A design that let the clear win would read 0 there, when the flag should be set again at once. It holds the pin steady across changes of trigger code, which catches a detector that invents edges from its own history. It drives the wrong-direction transition in each edge mode, which exposes a swapped edge polarity. It also counts the exact synchroniser latency, so a missing or extra flop stage is caught. Writes of zero to pending and writes to the unused enable offset show whether decode or clear logic is too loose.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO  = 2'd0,
    TRIG_EDG_FAL = 2'd1,
    TRIG_LVL_HI  = 2'd2,
    TRIG_EDG_RIS = 2'd3
  } trig_mode_e;

  localparam int unsigned DATA_W      = 32;
  localparam logic [7:0]  OFF_CTRL    = 8'h00;
  localparam logic [7:0]  OFF_PEND    = 8'h04;
  localparam logic [7:0]  OFF_EN_STD  = 8'h08;
  localparam logic [7:0]  OFF_EN_ALT  = 8'h34;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      assign stage_d = d_i;
    end else begin : g_many
      assign stage_d = {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  trig_mode_e mode_i,
  output logic       trig_o
);
  logic prev_q;
  logic rise;
  logic fall;

  // The previous sample always follows the synchronised level, so a change
  // of trigger code compares against the current pin state and sees no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      TRIG_LVL_LO:  trig_o = ~lvl_i;
      TRIG_EDG_FAL: trig_o = fall;
      TRIG_LVL_HI:  trig_o = lvl_i;
      TRIG_EDG_RIS: trig_o = rise;
      default:      trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter bit          ALT_LAYOUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              trig_i,
  output logic [DATA_W-1:0] prdata,
  output trig_mode_e        mode_o,
  output logic              pend_o,
  output logic              en_o
);
  localparam logic [7:0] OFF_EN = ALT_LAYOUT ? OFF_EN_ALT : OFF_EN_STD;
  localparam logic [ADDR_W-1:0] A_CTRL = OFF_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PEND = OFF_PEND[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_EN   = OFF_EN[ADDR_W-1:0];

  trig_mode_e mode_q, mode_d;
  logic       pend_q, pend_d;
  logic       en_q, en_d;
  logic       wr_acc;
  logic       wr_ctrl, wr_pend, wr_en;
  logic       clr_req;

  assign wr_acc  = psel & penable & pwrite;
  assign wr_ctrl = wr_acc & (paddr == A_CTRL);
  assign wr_pend = wr_acc & (paddr == A_PEND);
  assign wr_en   = wr_acc & (paddr == A_EN);
  assign clr_req = wr_pend & pwdata[0];

  always_comb begin
    mode_d = mode_q;
    en_d   = en_q;
    if (wr_ctrl) mode_d = trig_mode_e'(pwdata[1:0]);
    if (wr_en)   en_d   = pwdata[0];
    // a new event overrides a clear in the same cycle
    pend_d = trig_i | (pend_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRIG_LVL_LO;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (paddr == A_CTRL)      prdata[1:0] = mode_q;
      else if (paddr == A_PEND) prdata[0]   = pend_q;
      else if (paddr == A_EN)   prdata[0]   = en_q;
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter bit          ALT_LAYOUT  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              nmi_pin_i,
  output logic              irq_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       pin_s;
  logic       trig_evt;
  trig_mode_e mode_q;
  logic       pend_q;
  logic       en_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_pipe_q <= 2'b00;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (pclk),
    .rst_n (rst_sync_n),
    .d_i   (nmi_pin_i),
    .q_o   (pin_s)
  );

  nmi_detect u_detect (
    .clk    (pclk),
    .rst_n  (rst_sync_n),
    .lvl_i  (pin_s),
    .mode_i (mode_q),
    .trig_o (trig_evt)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .ALT_LAYOUT(ALT_LAYOUT)) u_regs (
    .clk     (pclk),
    .rst_n   (rst_sync_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .trig_i  (trig_evt),
    .prdata  (prdata),
    .mode_o  (mode_q),
    .pend_o  (pend_q),
    .en_o    (en_q)
  );

  assign irq_o = pend_q & en_q;
endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter bit          ALT_LAYOUT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              irq_o,
  input logic              trig,
  input logic              pend,
  input logic [1:0]        mode
);
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_EN   = ALT_LAYOUT ? ADDR_W'(52) : ADDR_W'(8);

  logic wr;
  assign wr = psel & penable & pwrite;

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && paddr == A_CTRL) |-> (prdata[31:2] == 30'd0)); // R2

  AST_EVENT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend); // R10

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_PEND && pwdata[0] && !trig) |=> !pend); // R7

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr && paddr == A_PEND && pwdata[0])) |=> pend); // R7

  AST_MASK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_EN && !pwdata[0]) |=> !irq_o); // R8

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend); // R9

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && trig) |=> (!trig || mode != $past(mode))); // R5
endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(.ADDR_W(ADDR_W), .ALT_LAYOUT(ALT_LAYOUT)) u_chk (
  .clk     (pclk),
  .rst_n   (rst_sync_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .irq_o   (irq_o),
  .trig    (trig_evt),
  .pend    (pend_q),
  .mode    (mode_q)
);

// File: tb/nmi_line_ctrl_tb.sv
module nmi_line_ctrl_tb;
  localparam int unsigned ADDR_W = 6;
  localparam bit          LAYOUT = 1'b0;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_EN   = LAYOUT ? ADDR_W'(52) : ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_ENX  = LAYOUT ? ADDR_W'(8)  : ADDR_W'(52);

  logic              pclk = 1'b0;
  logic              presetn = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              nmi_pin = 1'b1;
  logic              irq;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] act;
    string       tag;
  } item_t;
  item_t exp_q[$];
  event  item_ev;
  int    n_cmp = 0, n_bad = 0, cycles = 0;
  bit    done = 1'b0;

  always #2 pclk = ~pclk;

  nmi_line_ctrl #(.ADDR_W(ADDR_W), .ALT_LAYOUT(LAYOUT)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .nmi_pin_i(nmi_pin), .irq_o(irq)
  );

  task automatic drain();
    while (exp_q.size() > 0) begin
      item_t it = exp_q.pop_front();
      n_cmp++;
      if (it.act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %0h expected %0h", it.tag, it.act, it.exp);
      end
    end
  endtask

  // monitor
  initial forever begin
    @(item_ev);
    drain();
  end

  task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
    exp_q.push_back('{exp: exp, act: act, tag: tag});
    -> item_ev;
    #0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk);
    penable = 1;
    push(prdata, exp, tag);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  always @(posedge pclk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    presetn = 1;
    cyc(4);
    // R1 reset state
    apb_chk(A_CTRL, 0, "R1 ctrl");
    apb_chk(A_PEND, 0, "R1 pend");
    apb_chk(A_EN,   0, "R1 en");
    push({31'd0, irq}, 0, "R1 irq");

    // R2 only mode bits stored; R11 change with steady pin
    apb_wr(A_CTRL, 32'hFFFF_FFFF);
    apb_chk(A_CTRL, 3, "R2 ctrl readback");
    apb_chk(A_PEND, 0, "R11 no event 0->3");

    // R5 rising edge
    nmi_pin = 0; cyc(4);
    apb_chk(A_PEND, 0, "R5 fall ignored");
    nmi_pin = 1; cyc(4);
    apb_chk(A_PEND, 1, "R5 rise latched");
    push({31'd0, irq}, 0, "R9 masked");
    apb_wr(A_EN, 1);
    push({31'd0, irq}, 1, "R9 irq on");
    apb_wr(A_PEND, 0);
    apb_chk(A_PEND, 1, "R7 zero write");
    apb_wr(A_PEND, 1);
    apb_chk(A_PEND, 0, "R5 no relatch");
    push({31'd0, irq}, 0, "R9 irq off");

    // R6 falling edge
    apb_wr(A_CTRL, 1);
    nmi_pin = 0; cyc(4);
    apb_chk(A_PEND, 1, "R6 fall latched");
    apb_wr(A_PEND, 1);
    cyc(3);
    apb_chk(A_PEND, 0, "R6 low held");

    // R4 active-low level
    apb_wr(A_CTRL, 0);
    cyc(2);
    apb_chk(A_PEND, 1, "R4 low level");
    apb_wr(A_PEND, 1);
    apb_chk(A_PEND, 1, "R10 clear lost to level");
    nmi_pin = 1; cyc(4);
    apb_wr(A_PEND, 1);
    apb_chk(A_PEND, 0, "R4 cleared when inactive");

    // R3 active-high level and latency
    apb_wr(A_CTRL, 3);
    nmi_pin = 0; cyc(4);
    apb_wr(A_CTRL, 2);
    apb_wr(A_PEND, 1);
    apb_chk(A_PEND, 0, "R3 idle");
    @(negedge pclk); nmi_pin = 1;
    cyc(2);
    push({31'd0, irq}, 0, "R3 not after two edges");
    cyc(1);
    push({31'd0, irq}, 1, "R3 after third edge");
    apb_wr(A_PEND, 1);
    apb_chk(A_PEND, 1, "R3 relatch while high");
    nmi_pin = 0; cyc(4);
    apb_wr(A_PEND, 1);
    apb_chk(A_PEND, 0, "R3 cleared");

    // R8 enable decode
    apb_wr(A_EN, 0);
    apb_wr(A_ENX, 1);
    apb_chk(A_EN, 0, "R8 other offset ignored");
    apb_wr(A_EN, 32'hFFFF_FFFF);
    apb_chk(A_EN, 1, "R8 enable bit");

    // R11 edge-code change with steady low pin
    apb_wr(A_CTRL, 1);
    cyc(4);
    apb_chk(A_PEND, 0, "R11 no event 2->1");
    push({31'd0, irq}, 0, "R11 irq quiet");

    cyc(2);
    drain();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule